// File: doc/BRIEF.md
# Hash Engine Control Sequencer

This block is the register-facing controller that sits in front of a combined MD5/SHA-1 hashing engine. Software enables the engine through a control register, picks the algorithm, and either starts from the standard initial chaining values or resumes a partially hashed message by loading five chaining words first. Message words are pushed into a 32-word receive queue. The engine takes them a 16-word block at a time, and each block is followed by a fixed round latency. When software sets the data-end flag, the sequencer drains whatever words are still queued and runs a final round. It then clears the flag by itself and copies the chaining state into the digest registers on the following clock.

The round arithmetic is represented by a stand-in mixing core with the same interface and a fixed latency. For each consumed word `w`, in arrival order, every chaining word `h[i]` (i = 0..4) becomes `rotl(h[i], i+1) + w`. Because this fold does not depend on word position, hashing a message in one pass gives the same state as hashing it in two passes that hand the chaining words back through the IV registers. Software closes every operation by writing zero to the control register.

The sequencer is a seven-state machine:
- **OFF**: disabled.
- **COLLECT**: enabled and waiting for a full block or for data-end.
- **ABSORB**: pops one word per cycle, 16 in all.
- **ROUND**: block latency.
- **DRAIN**: pops the remaining words after data-end.
- **FINAL**: final latency; data-end clears as it ends.
- **SETTLE**: the digest registers load on its clock.

The transitions are:
- OFF→COLLECT on an enabling write.
- COLLECT→ABSORB when at least 16 words are queued.
- COLLECT→DRAIN when data-end is set and the queue is not empty.
- COLLECT→FINAL when data-end is set and the queue is empty.
- ABSORB→ROUND after the sixteenth pop.
- ROUND→COLLECT after the latency.
- DRAIN→FINAL once the queue is empty.
- FINAL→SETTLE after the latency.
- SETTLE→COLLECT.
- Any state→OFF on a control write with the enable bit clear.

Top module: `hash_seq_ctrl`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the status word (address 7) reads 0x20 (32 free slots, no overflow), and all five digest words (addresses 8 to 12) read 0.
- R2: The control word holds enable in bit 0, data-end in bit 1, and the resume (arbitrary IV) select in bit 2. Bits 5:4 hold the mode, where 01 means SHA-1 and 10 means MD5. All of these read back as written while enabled.
- R3: An enabling write with bit 2 clear starts from the standard values 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0. Each accepted word then folds into the state as `h[i] = rotl(h[i], i+1) + w`.
- R4: An enabling write with bit 2 set starts from the five IV registers (addresses 1 to 5, read/write). A message resumed with the previous chaining words gives the same digest as the message hashed in one pass.
- R5: The status bits 5:0 report the free slots. This field reads 32 right after enabling and falls by one for each accepted word written to the queue (address 6).
- R6: A queue write while the queue is full is dropped and sets the sticky overflow flag in status bit 8.
- R7: Data-end stays set until every queued word has been processed and the final latency has elapsed, then clears itself. With default parameters this happens within 100 cycles.
- R8: The digest registers change exactly one clock after data-end clears. In the cycle where data-end first reads 0, they still hold their previous values.
- R9: In MD5 mode the digest is four words and address 12 reads 0. In SHA-1 mode all five words are loaded.
- R10: A control write with bit 0 clear disables the engine. It empties the queue (32 free), clears overflow and data-end, aborts any pending completion, and leaves the digest registers unchanged.
- R11: Queue writes while the engine is disabled are ignored: the free count stays 32, no overflow is flagged, and no word reaches the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Word address of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The failure modes worth covering here are a wrong internal state or a miscounted wait. Either would show at the ports as a data-end flag that never falls within the poll limit, or as digest words that differ from the fold model for the very next message. A corrupted chaining state stays hidden until the next completion and then shows in every digest word. The resume test carries such an error across a disable, so it also shows in the second half of a split message. Publishing the digest too early or too late is caught in the single cycle where data-end first reads zero, by checking that the digest still holds the previous result.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
    localparam int HW        = 32;
    localparam int NH        = 5;
    localparam int MD5_WORDS = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_COLLECT,
        ST_ABSORB,
        ST_ROUND,
        ST_DRAIN,
        ST_FINAL,
        ST_SETTLE
    } seq_state_t;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_IV0  = 4'd1;
    localparam logic [3:0] A_FIFO = 4'd6;
    localparam logic [3:0] A_STAT = 4'd7;
    localparam logic [3:0] A_DIG0 = 4'd8;

    localparam int CB_EN   = 0;
    localparam int CB_DE   = 1;
    localparam int CB_ARB  = 2;
    localparam int CB_MODE = 4;
    localparam int SB_OVF  = 8;

    localparam logic [1:0] MODE_SHA1 = 2'b01;
    localparam logic [1:0] MODE_MD5  = 2'b10;

    function automatic logic [HW-1:0] std_iv(input int idx);
        logic [HW-1:0] v;
        case (idx)
            0:       v = 32'h6745_2301;
            1:       v = 32'hEFCD_AB89;
            2:       v = 32'h98BA_DCFE;
            3:       v = 32'h1032_5476;
            default: v = 32'hC3D2_E1F0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/hs_word_fifo.sv
`timescale 1ns/1ps
module hs_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/hs_mix_core.sv
`timescale 1ns/1ps
module hs_mix_core #(
    parameter int W = 32,
    parameter int N = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [N-1:0][W-1:0] load_val,
    input  logic                step,
    input  logic [W-1:0]        word,
    output logic [N-1:0][W-1:0] h
);
    logic [N-1:0][W-1:0] h_q;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int s);
        return (x << s) | (x >> (W - s));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else if (load) begin
            h_q <= load_val;
        end else if (step) begin
            for (int i = 0; i < N; i++) begin
                h_q[i] <= rotl(h_q[i], i + 1) + word;
            end
        end
    end

    assign h = h_q;
endmodule

// File: rtl/hs_seq_fsm.sv
`timescale 1ns/1ps
module hs_seq_fsm
    import hs_pkg::*;
#(
    parameter int CW          = 6,
    parameter int BLOCK_WORDS = 16,
    parameter int ROUND_LAT   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          de_req,
    input  logic [CW-1:0] fifo_cnt,
    input  logic          fifo_empty,
    output seq_state_t    state,
    output logic          load_h,
    output logic          pop,
    output logic          de_clr,
    output logic          publish
);
    localparam int WMAX = (BLOCK_WORDS > ROUND_LAT) ? BLOCK_WORDS : ROUND_LAT;
    localparam int WCW  = $clog2(WMAX + 1);
    localparam logic [WCW-1:0] BLK_LAST = WCW'(BLOCK_WORDS - 1);
    localparam logic [WCW-1:0] LAT_LAST = WCW'(ROUND_LAT - 1);

    seq_state_t     state_q, state_d;
    logic [WCW-1:0] wcnt_q;
    logic           timed;

    assign timed = (state_q == ST_ABSORB) || (state_q == ST_ROUND) || (state_q == ST_FINAL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     if (start) state_d = ST_COLLECT;
                ST_COLLECT: begin
                    if (fifo_cnt >= CW'(BLOCK_WORDS)) state_d = ST_ABSORB;
                    else if (de_req) state_d = fifo_empty ? ST_FINAL : ST_DRAIN;
                end
                ST_ABSORB:  if (wcnt_q == BLK_LAST) state_d = ST_ROUND;
                ST_ROUND:   if (wcnt_q == LAT_LAST) state_d = ST_COLLECT;
                ST_DRAIN:   if (fifo_empty) state_d = ST_FINAL;
                ST_FINAL:   if (wcnt_q == LAT_LAST) state_d = ST_SETTLE;
                ST_SETTLE:  state_d = ST_COLLECT;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // state register and dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || !timed) wcnt_q <= '0;
            else                             wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_h  = 1'b0;
        pop     = 1'b0;
        de_clr  = 1'b0;
        publish = 1'b0;
        unique case (state_q)
            ST_OFF:     load_h  = start;
            ST_COLLECT: ;
            ST_ABSORB:  pop     = 1'b1;
            ST_ROUND:   ;
            ST_DRAIN:   pop     = !fifo_empty;
            ST_FINAL:   de_clr  = (wcnt_q == LAT_LAST);
            ST_SETTLE:  publish = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/hash_seq_ctrl.sv
`timescale 1ns/1ps
module hash_seq_ctrl
    import hs_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int BLOCK_WORDS = 16,
    parameter int ROUND_LAT   = 12,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HW-1:0]     reg_wdata,
    output logic [HW-1:0]     reg_rdata
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic                 en_q, de_q, arb_q, ovf_q;
    logic [1:0]           mode_q;
    logic [NH-1:0][HW-1:0] iv_q, dig_q, h_w, std_w, load_val;
    logic                 ctl_wr, start, stop, fifo_wr;
    logic [CW-1:0]        fifo_cnt;
    logic                 fifo_full, fifo_empty, pop, load_h, de_clr, publish;
    logic [HW-1:0]        fifo_dout;
    seq_state_t           seq_state;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign start   = ctl_wr && reg_wdata[CB_EN] && !en_q;
    assign stop    = ctl_wr && !reg_wdata[CB_EN];
    assign fifo_wr = reg_wr && (reg_addr == ADDR_W'(A_FIFO)) && en_q;

    for (genvar g = 0; g < NH; g++) begin : g_std
        assign std_w[g] = std_iv(g);
    end
    assign load_val = reg_wdata[CB_ARB] ? iv_q : std_w;

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            de_q   <= 1'b0;
            arb_q  <= 1'b0;
            mode_q <= '0;
        end else if (stop) begin
            en_q   <= 1'b0;
            de_q   <= 1'b0;
            arb_q  <= 1'b0;
            mode_q <= '0;
        end else if (start) begin
            en_q   <= 1'b1;
            de_q   <= reg_wdata[CB_DE];
            arb_q  <= reg_wdata[CB_ARB];
            mode_q <= reg_wdata[CB_MODE +: 2];
        end else if (ctl_wr && reg_wdata[CB_DE]) begin
            de_q <= 1'b1;
        end else if (de_clr) begin
            de_q <= 1'b0;
        end
    end

    // IV registers, sticky overflow, digest registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iv_q  <= '0;
            dig_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            for (int k = 0; k < NH; k++) begin
                if (reg_wr && reg_addr == ADDR_W'(int'(A_IV0) + k)) iv_q[k] <= reg_wdata;
                if (publish) begin
                    dig_q[k] <= (mode_q == MODE_MD5 && k >= MD5_WORDS) ? '0 : h_w[k];
                end
            end
            if (stop)                        ovf_q <= 1'b0;
            else if (fifo_wr && fifo_full)   ovf_q <= 1'b1;
        end
    end

    hs_word_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (stop),
        .push  (fifo_wr),
        .din   (reg_wdata),
        .pop   (pop),
        .dout  (fifo_dout),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    hs_mix_core #(.W(HW), .N(NH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_h),
        .load_val (load_val),
        .step     (pop),
        .word     (fifo_dout),
        .h        (h_w)
    );

    hs_seq_fsm #(.CW(CW), .BLOCK_WORDS(BLOCK_WORDS), .ROUND_LAT(ROUND_LAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .de_req     (de_q),
        .fifo_cnt   (fifo_cnt),
        .fifo_empty (fifo_empty),
        .state      (seq_state),
        .load_h     (load_h),
        .pop        (pop),
        .de_clr     (de_clr),
        .publish    (publish)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[CB_EN]          = en_q;
            reg_rdata[CB_DE]          = de_q;
            reg_rdata[CB_ARB]         = arb_q;
            reg_rdata[CB_MODE +: 2]   = mode_q;
        end else if (reg_addr == ADDR_W'(A_STAT)) begin
            reg_rdata[CW-1:0]         = CW'(FIFO_DEPTH) - fifo_cnt;
            reg_rdata[SB_OVF]         = ovf_q;
        end
        for (int k = 0; k < NH; k++) begin
            if (reg_addr == ADDR_W'(int'(A_IV0) + k))  reg_rdata = iv_q[k];
            if (reg_addr == ADDR_W'(int'(A_DIG0) + k)) reg_rdata = dig_q[k];
        end
    end
endmodule

// File: rtl/hash_seq_ctrl_chk.sv
`timescale 1ns/1ps
module hash_seq_ctrl_chk
    import hs_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [HW-1:0]         reg_wdata,
    input logic                  en_q,
    input logic                  de_q,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic                  fifo_full,
    input logic                  ovf_q,
    input logic [NH-1:0][HW-1:0] iv_q,
    input logic [NH-1:0][HW-1:0] dig_q,
    input logic [NH-1:0][HW-1:0] h_w,
    input logic [NH-1:0][HW-1:0] std_w,
    input seq_state_t            seq_state
);
    logic ctl_wr, q_wr;
    assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign q_wr   = reg_wr && (reg_addr == ADDR_W'(A_FIFO));

    assert_fresh_iv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[CB_EN] && !en_q && !reg_wdata[CB_ARB]) |=> (h_w == std_w));

    assert_resume_iv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[CB_EN] && !en_q && reg_wdata[CB_ARB]) |=> (h_w == $past(iv_q)));

    assert_full_write_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && en_q && fifo_full) |=> ovf_q);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && en_q && fifo_full) |=> (fifo_cnt <= $past(fifo_cnt)));

    assert_de_clears_only_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de_q) |-> ($past(seq_state) == ST_FINAL || !en_q));

    assert_publish_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $fell(de_q)) |=> (dig_q[0] == $past(h_w[0])));

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !reg_wdata[CB_EN]) |=> (fifo_cnt == '0 && !ovf_q && !de_q && !en_q));

    assert_disabled_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && !en_q && !ctl_wr) |=> (fifo_cnt == '0 && !ovf_q));
endmodule

bind hash_seq_ctrl hash_seq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .en_q      (en_q),
    .de_q      (de_q),
    .fifo_cnt  (fifo_cnt),
    .fifo_full (fifo_full),
    .ovf_q     (ovf_q),
    .iv_q      (iv_q),
    .dig_q     (dig_q),
    .h_w       (h_w),
    .std_w     (std_w),
    .seq_state (seq_state)
);

// File: tb/hash_seq_ctrl_tb.sv
`timescale 1ns/1ps
module hash_seq_ctrl_tb;
    localparam logic [3:0] T_CTRL = 4'd0, T_IV0 = 4'd1, T_FIFO = 4'd6, T_STAT = 4'd7, T_DIG0 = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;

    hash_seq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mh [5];
    logic [31:0] exp_dig [5] = '{default: 32'h0};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic rd_now(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.3 v = reg_rdata;
    endtask

    function automatic logic [31:0] rotl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [31:0] wgen(input int s, input int k);
        logic [31:0] a = 32'(s * 7919 + k);
        return (a * 32'h9E3779B9) ^ {a[15:0], a[31:16]};
    endfunction

    task automatic m_std();
        mh[0] = 32'h67452301; mh[1] = 32'hEFCDAB89; mh[2] = 32'h98BADCFE;
        mh[3] = 32'h10325476; mh[4] = 32'hC3D2E1F0;
    endtask

    task automatic put_words(input int seed, input int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] w = wgen(seed, k);
            wr(T_FIFO, w);
            for (int i = 0; i < 5; i++) mh[i] = rotl(mh[i], i + 1) + w;
        end
    endtask

    // set data-end, poll it, check stale/new digest
    task automatic finish_msg(input logic [31:0] ctl, input string tag);
        logic [31:0] v;
        int polls = 0;
        bit md5 = (ctl[5:4] == 2'b10);
        wr(T_CTRL, ctl);
        do begin
            rd(T_CTRL, v);
            polls++;
        end while (v[1] && polls < 100);
        check("R7 data-end clears within 100 polls", {31'b0, (polls < 100)}, 32'd1);
        rd_now(T_DIG0, v);
        check("R8 digest still old when data-end first reads 0", v, exp_dig[0]);
        for (int i = 0; i < 5; i++) exp_dig[i] = (md5 && i == 4) ? 32'h0 : mh[i];
        for (int i = 0; i < 5; i++) begin
            rd(T_DIG0 + 4'(i), v);
            check(tag, v, exp_dig[i]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(T_CTRL, v); check("R1 control after reset", v, 32'h0);
        rd(T_STAT, v); check("R1 status after reset", v, 32'h20);
        for (int i = 0; i < 5; i++) begin
            rd(T_DIG0 + 4'(i), v); check("R1 digest after reset", v, 32'h0);
        end
    endtask

    task automatic t_fresh_sha1();
        logic [31:0] v;
        m_std();
        wr(T_CTRL, 32'h11);
        rd(T_CTRL, v); check("R2 control readback sha1", v, 32'h11);
        rd(T_STAT, v); check("R5 free slots after enable", v, 32'h20);
        put_words(1, 3);
        rd(T_STAT, v); check("R5 free slots after three words", v, 32'd29);
        put_words(2, 17);
        finish_msg(32'h13, "R3 fresh sha1 digest");
        wr(T_CTRL, 32'h0);
    endtask

    task automatic t_md5();
        logic [31:0] v;
        m_std();
        wr(T_CTRL, 32'h21);
        rd(T_CTRL, v); check("R2 control readback md5", v, 32'h21);
        put_words(3, 7);
        finish_msg(32'h23, "R9 md5 four-word digest");
        wr(T_CTRL, 32'h0);
    endtask

    task automatic t_resume();
        logic [31:0] v;
        m_std();
        wr(T_CTRL, 32'h11);
        put_words(4, 18);
        finish_msg(32'h13, "R3 first part digest");
        wr(T_CTRL, 32'h0);
        rd(T_DIG0, v); check("R10 digest kept after disable", v, exp_dig[0]);
        for (int i = 0; i < 5; i++) wr(T_IV0 + 4'(i), exp_dig[i]);
        rd(T_IV0 + 4'd2, v); check("R4 IV register readback", v, exp_dig[2]);
        wr(T_CTRL, 32'h15);
        rd(T_CTRL, v); check("R2 control readback resume", v, 32'h15);
        put_words(5, 9);
        finish_msg(32'h17, "R4 resumed digest equals one-pass digest");
        wr(T_CTRL, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(T_CTRL, 32'h11);
        for (int k = 0; k < 90; k++) wr(T_FIFO, 32'(k));
        rd(T_STAT, v); check("R6 sticky overflow after burst", {31'b0, v[8]}, 32'd1);
        repeat (40) @(posedge clk);
        rd(T_STAT, v); check("R6 overflow stays set", {31'b0, v[8]}, 32'd1);
        wr(T_CTRL, 32'h0);
        rd(T_STAT, v); check("R10 disable empties queue and clears overflow", v, 32'h20);
        rd(T_CTRL, v); check("R10 control reads 0 after disable", v, 32'h0);
    endtask

    task automatic t_stop_mid();
        logic [31:0] v;
        m_std();
        wr(T_CTRL, 32'h11);
        put_words(6, 10);
        wr(T_CTRL, 32'h13);
        wr(T_CTRL, 32'h0);
        rd(T_CTRL, v); check("R10 data-end cleared by disable", v, 32'h0);
        rd(T_STAT, v); check("R10 queue empty after disable", v, 32'h20);
        repeat (40) @(posedge clk);
        rd(T_DIG0, v); check("R10 aborted completion leaves digest", v, exp_dig[0]);
    endtask

    task automatic t_disabled_ignored();
        logic [31:0] v;
        for (int k = 0; k < 3; k++) wr(T_FIFO, 32'hDEAD_0000 + 32'(k));
        rd(T_STAT, v); check("R11 writes while disabled ignored", v, 32'h20);
        m_std();
        wr(T_CTRL, 32'h11);
        finish_msg(32'h13, "R11 no stray words in empty message");
        wr(T_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_fresh_sha1();
                t_md5();
                t_resume();
                t_overflow();
                t_stop_mid();
                t_disabled_ignored();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule